// File: doc/BRIEF.md
# Strobed Watchdog Timer With Write Lock

The block is a software watchdog that counts down a slow time base, one step per tick of an external 32 Hz enable. Software owns a single byte-wide control register. Writing it can restart the countdown, change the timeout, or both. If the countdown runs out before software restarts it, the block emits a one-clock expiry event for a downstream interrupt stage and raises a sticky watchdog flag. The flag stays set until the flag-clear input is pulsed.

The register has three fields. A restart bit is write-only and clears itself. A lock bit protects the timeout field. A 6-bit field sets the timeout as a multiple of the tick period, from 1 tick (31.25 ms) up to 63 ticks (about 2 s). A timeout of zero turns the watchdog off. With the lock set, software can keep writing the restart bit without having to know or resend the timeout value.

Top module: `wdog_strobe_top`

## Requirements
- R1: After reset the read port returns 0x00, the flag and the event are low, and the watchdog is disabled because the timeout field is 0.
- R2: Control byte layout: bit 7 is the restart (strobe) bit, bit 6 is the lock bit and bits 5..0 are the timeout. A read returns {0, lock, timeout}.
- R3: Writing 1 to bit 7 restarts the countdown at the full timeout. A write with bit 7 at 0 that leaves the timeout unchanged does not restart it.
- R4: The strobe bit is never stored and always reads back as 0.
- R5: Every write stores bit 6 as the new lock. While the lock held before the write is 1, bits 5..0 of that write are ignored.
- R6: A write made while the lock held before the write is 0 loads bits 5..0 as the timeout and restarts the countdown.
- R7: With a timeout N between 1 and 63, the expiry event occurs on the Nth tick after the last restart. The countdown then starts again at N.
- R8: With a timeout of 0, ticks never produce an expiry event or set the flag.
- R9: The expiry event lasts exactly one clock cycle.
- R10: The flag is set by an expiry, whether or not any interrupt is in use. It stays set until flag_clr_i is asserted, and a set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the 32 Hz rate |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control byte to write |
| rd_data_o | output | 8 | Control register readback |
| flag_clr_i | input | 1 | Clears the watchdog flag |
| wd_flag_o | output | 1 | Sticky watchdog flag |
| wd_event_o | output | 1 | One-cycle expiry event |

## Verification
The assertions check the following on every cycle: a locked write leaves the timeout unchanged, a zero timeout produces no event, an event is always followed by a set flag, and a clear without a set drops the flag. The bench scenarios show what only the tick sequence can reveal. These are the exact tick count from a restart to expiry at 1, 3, 5 and 63, the automatic restart after expiry, a restart written while locked, a lock-only write that does not restart, and the readback of every field.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned TO_W       = 6;
  parameter int unsigned STROBE_BIT = 7;
  parameter int unsigned LOCK_BIT   = 6;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [TO_W-1:0]   timeout_o,
  output logic              lock_o,
  output logic              reload_o
);
  logic [TO_W-1:0] timeout_q;
  logic            lock_q;
  logic            reload_q;  // self-clearing strobe, one cycle
  logic            strobe_w;

  assign strobe_w = wr_data_i[STROBE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= '0;
      lock_q    <= 1'b0;
      reload_q  <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (wr_en_i) begin
        lock_q <= wr_data_i[LOCK_BIT];
        if (!lock_q) timeout_q <= wr_data_i[TO_W-1:0];
        reload_q <= strobe_w || !lock_q;
      end
    end
  end

  assign timeout_o = timeout_q;
  assign lock_o    = lock_q;
  assign reload_o  = reload_q;

  assert_lock_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_q) |=> $stable(timeout_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            reload_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            event_o
);
  logic [TO_W-1:0] count_q;
  logic            event_q;
  logic            enabled;
  logic            expire;

  assign enabled = (timeout_i != '0);
  assign expire  = tick_i && enabled && !reload_i && (count_q <= TO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      event_q <= 1'b0;
    end else begin
      event_q <= expire;
      if (reload_i) begin
        count_q <= timeout_i;
      end else if (tick_i && enabled) begin
        if (count_q <= TO_W'(1)) count_q <= timeout_i;
        else                     count_q <= count_q - TO_W'(1);
      end
    end
  end

  assign event_o = event_q;

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i == '0) |=> !event_q);
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_flag_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/wdog_strobe_top.sv
module wdog_strobe_top
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              flag_clr_i,
  output logic              wd_flag_o,
  output logic              wd_event_o
);
  logic [TO_W-1:0] timeout;
  logic            lock;
  logic            reload;

  wdog_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .timeout_o(timeout), .lock_o(lock), .reload_o(reload)
  );

  wdog_counter u_cnt (
    .clk_i, .rst_ni, .tick_i, .reload_i(reload),
    .timeout_i(timeout), .event_o(wd_event_o)
  );

  wdog_flag u_flag (
    .clk_i, .rst_ni, .set_i(wd_event_o), .clr_i(flag_clr_i), .flag_o(wd_flag_o)
  );

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[TO_W-1:0]   = timeout;
    rd_data_o[LOCK_BIT]   = lock;
    rd_data_o[STROBE_BIT] = 1'b0;  // write-only
  end
endmodule

// File: tb/tb_wdog_strobe_top.sv
module tb_wdog_strobe_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       wd_flag;
  logic       wd_event;

  int checks = 0;
  int fails  = 0;
  int tick_idx = 0;
  int exp_q[$];
  logic prev_evt = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  wdog_strobe_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .flag_clr_i(flag_clr),
    .wd_flag_o(wd_flag), .wd_event_o(wd_event)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; tick_idx++;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    chk(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: pops expected tick index on every event
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && wd_event) begin
        if (exp_q.size() == 0) chk("R7/R8 unexpected event", tick_idx, -1);
        else                   chk("R7 expiry tick", tick_idx, exp_q.pop_front());
        chk("R9 single-cycle event", int'(prev_evt), 0);
      end
      prev_evt = wd_event;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 flag", wd_flag, 0);
    chk("R1 event", wd_event, 0);

    // R1/R8: disabled after reset
    ticks(10);
    drained("R8 no event at timeout 0");
    chk("R8 flag", wd_flag, 0);

    // R6/R2/R4: timeout 3, strobe in write reads as 0
    wr(8'h83);
    chk("R2 R4 readback", rd_data, 8'h03);
    exp_q.push_back(tick_idx + 3);
    exp_q.push_back(tick_idx + 6);
    ticks(6);
    drained("R7 expiry and restart");
    chk("R10 flag set", wd_flag, 1);
    ticks(2);
    chk("R10 flag held", wd_flag, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R10 flag cleared", wd_flag, 0);

    // count is now 1 left; unlocked write with lock bit reloads (R6)
    wr(8'h43);
    chk("R5 lock readback", rd_data, 8'h43);
    ticks(2);
    // R3: strobe 0, locked -> no restart, timeout 0 ignored (R5)
    wr(8'h40);
    chk("R5 locked timeout kept", rd_data, 8'h43);
    exp_q.push_back(tick_idx + 1);
    ticks(1);
    drained("R3 no restart on strobe 0");

    // R3: strobe while locked restarts
    ticks(1);
    wr(8'hC0);
    chk("R4 R5 readback after locked strobe", rd_data, 8'h43);
    exp_q.push_back(tick_idx + 3);
    ticks(3);
    drained("R3 locked strobe restart");

    // R5: unlock write ignores its timeout field
    wr(8'h00);
    chk("R5 unlock keeps timeout", rd_data, 8'h03);
    wr(8'h05);
    chk("R6 new timeout", rd_data, 8'h05);
    exp_q.push_back(tick_idx + 5);
    ticks(5);
    drained("R6 R7 timeout 5");

    // R7 boundaries
    wr(8'h01);
    chk("R6 timeout 1", rd_data, 8'h01);
    exp_q.push_back(tick_idx + 1);
    exp_q.push_back(tick_idx + 2);
    ticks(2);
    drained("R7 timeout 1");

    wr(8'h3F);
    chk("R6 timeout 63", rd_data, 8'h3F);
    exp_q.push_back(tick_idx + 63);
    ticks(63);
    drained("R7 timeout 63");

    // R8: writing 0 disables
    wr(8'h00);
    chk("R8 readback", rd_data, 8'h00);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    ticks(70);
    drained("R8 disabled by write");
    chk("R8 flag stays low", wd_flag, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule